// File: doc/BRIEF.md
# Two-Phase Stepper Phase Sequencer

This block turns a slow, asynchronous step clock into winding commands for a two-phase stepper driver. It keeps a position on an eight-slot electrical ring, spaced 45 degrees apart. Each rising step-clock edge moves that position by one increment of the selected stepping mode, forward or backward as `dir_i` selects. The position drives the enable and polarity of each winding. When the step clock stops, the block holds its excitation, whichever level the clock stopped at.

There are two ways to coast the motor. The sleep request blanks every winding and keeps the sequencer running in the background. The reserved mode code blanks every winding and also parks the sequencer at home. A chopping-sync request reaches the power stage only while the motor is holding or running in dual-excitation full step. A power-on indication and an explicit sequencer reset both return the position to home. The step clock is brought into the system clock domain by a synchronizer chain and an edge detector. All other inputs are assumed synchronous to `clk_i`.

Top module: `step_sequencer`

## Requirements
- R1: While `rst_ni` is low, or while `por_i` is high at a clock edge, the position goes to home, slot 1. In that slot both windings are enabled with positive polarity.
- R2: When `seq_rst_i` is high at a clock edge, the position is home after that edge, whatever the step clock does.
- R3: Half step (mode code 000, and every code not listed in R4, R5 or R9) moves the position by exactly 1 per accepted step edge. The move is upward modulo 8 when `dir_i`=1 and downward when `dir_i`=0.
- R4: Dual-excitation full step (mode code 001) uses only odd slots and moves by 2. From an even slot, the first step moves by 1 in the step direction onto an odd slot.
- R5: Wave full step (mode code 010) uses only even slots and moves by 2. From an odd slot, the first step moves by 1 in the step direction onto an even slot.
- R6: A rising level on `step_clk_i` is first sampled at clock edge n, and the position changes at edge n+2. Holding the step clock high or low moves nothing further.
- R7: Winding A is positive in slots 7, 0 and 1, off in slots 2 and 6, and negative in slots 3, 4 and 5. Winding B follows the same pattern shifted by two slots. Direction bit 1 means positive polarity.
- R8: While `sleep1_i`=1, `out_en_o` and both winding enables are 0. Step edges still move the position.
- R9: Mode code 111 forces `out_en_o` and both enables to 0, holds the position at home and ignores step edges.
- R10: `sync_en_o` = `sync_req_i` AND `out_en_o` AND (hold OR mode code 001). Hold is true from reset until the next accepted edge. It is true again once HOLD_CYCLES clock cycles pass with no edge detected.
- R11: The mode and direction inputs act only at a step edge. Changing them without an edge leaves the position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on reset indication, active high |
| seq_rst_i | input | 1 | Sequencer reset to home, active high |
| step_clk_i | input | 1 | Asynchronous step clock |
| dir_i | input | 1 | Step direction, 1 = up |
| mode_i | input | 3 | Stepping mode code |
| sleep1_i | input | 1 | Coast request that keeps the position |
| sync_req_i | input | 1 | Chopping-sync request |
| phase_idx_o | output | 3 | Position slot 0..7 |
| phase_a_en_o | output | 1 | Winding A enable |
| phase_a_dir_o | output | 1 | Winding A polarity |
| phase_b_en_o | output | 1 | Winding B enable |
| phase_b_dir_o | output | 1 | Winding B polarity |
| out_en_o | output | 1 | Windings may be driven |
| sync_en_o | output | 1 | Effective chopping-sync enable |

## Verification
Each result is due at a different cycle:
- The position lags a step-clock rise by three clock edges: two synchronizer stages, then the register.
- A forced home (power-on, reset or the reserved mode) shows one edge after the request.
- Enables, `out_en_o` and `sync_en_o` follow the sleep, mode and sync inputs within the same cycle.
- The hold flag returns HOLD_CYCLES edges after the last detected step.

The reference model keeps the step level history as plain integers and applies these delays. It changes inputs only on falling clock edges and compares two nanoseconds after each rising edge, so every result is read in the cycle it becomes due.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int unsigned RING_SLOTS = 8;
  localparam int unsigned POS_W      = $clog2(RING_SLOTS);
  localparam int unsigned N_WIND     = 2;

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [2:0] {
    MODE_HALF = 3'b000,
    MODE_DUAL = 3'b001,
    MODE_WAVE = 3'b010,
    MODE_PARK = 3'b111
  } step_mode_e;

  localparam pos_t HOME_POS = pos_t'(1);

  typedef struct packed {
    logic en;
    logic pos_pol;
  } wind_t;
endpackage

// File: rtl/step_edge_sync.sv
module step_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

  a_r6_single_cycle_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/step_hold_timer.sv
module step_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic hold_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               idle_cnt <= LIMIT;
    else if (step_i)           idle_cnt <= '0;
    else if (idle_cnt < LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign hold_o = (idle_cnt == LIMIT);

  generate
    if (HOLD_CYCLES > 0) begin : g_chk
      a_r10_step_ends_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |=> !hold_o);
    end
  endgenerate
endmodule

// File: rtl/step_position.sv
module step_position
  import step_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       force_home_i,
  input  logic       step_i,
  input  logic       dir_i,
  input  step_mode_e mode_i,
  output pos_t       pos_o
);
  pos_t pos_q, pos_d, delta;
  logic want_odd, want_even, misaligned;

  always_comb begin
    want_odd   = (mode_i == MODE_DUAL);
    want_even  = (mode_i == MODE_WAVE);
    misaligned = (want_odd && !pos_q[0]) || (want_even && pos_q[0]);
    // single slot for half step or to land on the mode's parity
    delta      = (want_odd || want_even) && !misaligned ? pos_t'(2) : pos_t'(1);
    pos_d      = dir_i ? pos_q + delta : pos_q - delta;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pos_q <= HOME_POS;
    else if (force_home_i) pos_q <= HOME_POS;
    else if (step_i)       pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  a_r2_forced_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_home_i |=> pos_q == HOME_POS);
  a_r11_still_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !force_home_i |=> $stable(pos_q));
  a_r4_dual_lands_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !force_home_i && mode_i == MODE_DUAL |=> pos_q[0]);
  a_r5_wave_lands_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !force_home_i && mode_i == MODE_WAVE |=> !pos_q[0]);
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import step_seq_pkg::*;
(
  input  pos_t  pos_i,
  input  logic  out_en_i,
  output wind_t wind_o [N_WIND]
);
  generate
    for (genvar w = 0; w < int'(N_WIND); w++) begin : g_wind
      pos_t rel;
      // each further winding lags by a quarter of the ring
      assign rel = pos_i - pos_t'(2 * w);
      assign wind_o[w].en      = out_en_i && (rel != pos_t'(2)) && (rel != pos_t'(6));
      assign wind_o[w].pos_pol = (rel == pos_t'(7)) || (rel == pos_t'(0)) || (rel == pos_t'(1));
    end
  endgenerate
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import step_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       seq_rst_i,
  input  logic       step_clk_i,
  input  logic       dir_i,
  input  logic [2:0] mode_i,
  input  logic       sleep1_i,
  input  logic       sync_req_i,
  output logic [2:0] phase_idx_o,
  output logic       phase_a_en_o,
  output logic       phase_a_dir_o,
  output logic       phase_b_en_o,
  output logic       phase_b_dir_o,
  output logic       out_en_o,
  output logic       sync_en_o
);
  step_mode_e mode;
  logic       step_rise, hold, parked, force_home, out_en;
  pos_t       pos;
  wind_t      wind [N_WIND];

  assign mode       = step_mode_e'(mode_i);
  assign parked     = (mode == MODE_PARK);
  assign force_home = por_i | seq_rst_i | parked;
  assign out_en     = !sleep1_i && !parked;

  step_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(step_clk_i),
    .rise_o (step_rise)
  );

  step_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_rise),
    .hold_o(hold)
  );

  step_position u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_home_i(force_home),
    .step_i      (step_rise),
    .dir_i       (dir_i),
    .mode_i      (mode),
    .pos_o       (pos)
  );

  phase_decode u_dec (
    .pos_i   (pos),
    .out_en_i(out_en),
    .wind_o  (wind)
  );

  assign phase_idx_o   = pos;
  assign phase_a_en_o  = wind[0].en;
  assign phase_a_dir_o = wind[0].pos_pol;
  assign phase_b_en_o  = wind[1].en;
  assign phase_b_dir_o = wind[1].pos_pol;
  assign out_en_o      = out_en;
  assign sync_en_o     = sync_req_i && out_en && (hold || mode == MODE_DUAL);

  a_r10_sync_needs_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_o |-> out_en_o && sync_req_i);
  a_r8_coast_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> !phase_a_en_o && !phase_b_en_o);
  a_r7_one_winding_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> phase_a_en_o || phase_b_en_o);
  a_r9_park_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked && $past(parked) |-> phase_idx_o == 3'(HOME_POS));
endmodule

// File: tb/sim_step_sequencer.sv
module sim_step_sequencer;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic por = 1'b1, seq_rst = 1'b0, step = 1'b0, dir = 1'b1, sleep1 = 1'b0, sync_req = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [2:0] idx;
  logic a_en, a_dir, b_en, b_dir, oen, sen;

  int vecs = 0, miss = 0;
  string cur_tag = "R3";
  bit done = 1'b0;

  // reference state
  int m_pos = 1, m_cnt = HOLD, s1 = 0, s2 = 0, s3 = 0;

  always #10 clk = ~clk;

  step_sequencer #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .seq_rst_i(seq_rst),
    .step_clk_i(step), .dir_i(dir), .mode_i(mode), .sleep1_i(sleep1),
    .sync_req_i(sync_req), .phase_idx_o(idx), .phase_a_en_o(a_en),
    .phase_a_dir_o(a_dir), .phase_b_en_o(b_en), .phase_b_dir_o(b_dir),
    .out_en_o(oen), .sync_en_o(sen)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pos_dir(int p, int w);
    int r = (p - 2 * w + 8) % 8;
    return (r == 7 || r == 0 || r == 1);
  endfunction

  function automatic bit pos_on(int p, int w);
    int r = (p - 2 * w + 8) % 8;
    return !(r == 2 || r == 6);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 1; m_cnt = HOLD; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int  d;
      bit  edge_seen;
      edge_seen = (s2 == 1) && (s3 == 0);
      s3 = s2; s2 = s1; s1 = int'(step);
      if (edge_seen) m_cnt = 0;
      else if (m_cnt < HOLD) m_cnt++;
      if (por || seq_rst || mode == 3'b111) m_pos = 1;
      else if (edge_seen) begin
        if (mode == 3'b001)      d = (m_pos % 2 == 1) ? 2 : 1;
        else if (mode == 3'b010) d = (m_pos % 2 == 0) ? 2 : 1;
        else                     d = 1;
        m_pos = dir ? (m_pos + d) % 8 : (m_pos + 8 - d) % 8;
      end
    end
    #2;
    if (rst_n && !done) begin
      bit e_oen;
      e_oen = !sleep1 && mode != 3'b111;
      chk(cur_tag, 8'(idx), 8'(m_pos));
      chk("R7", {6'd0, a_en, b_en}, {6'd0, e_oen && pos_on(m_pos, 0), e_oen && pos_on(m_pos, 1)});
      chk("R7", {6'd0, a_dir, b_dir}, {6'd0, pos_dir(m_pos, 0), pos_dir(m_pos, 1)});
      chk("R8", 8'(oen), 8'(e_oen));
      chk("R10", 8'(sen), 8'(sync_req && e_oen && (m_cnt == HOLD || mode == 3'b001)));
    end
  end

  task automatic pulse(int hi, int lo);
    @(negedge clk) step = 1'b1;
    repeat (hi) @(negedge clk);
    step = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    chk("R1", 8'(idx), 8'd1);
    chk("R1", {4'd0, a_en, a_dir, b_en, b_dir}, 8'b0000_1111);

    cur_tag = "R3";
    repeat (5) pulse(3, 3);
    dir = 1'b0;
    repeat (7) pulse(2, 4);
    dir = 1'b1;
    repeat (10) pulse(3, 3);

    // R6 latency and level independence
    cur_tag = "R6";
    p0 = int'(idx);
    @(negedge clk) step = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6", 8'(idx), 8'(p0));
    @(negedge clk);
    chk("R6", 8'(idx), 8'((p0 + 1) % 8));
    repeat (12) @(negedge clk);
    chk("R6", 8'(idx), 8'((p0 + 1) % 8));
    step = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6", 8'(idx), 8'((p0 + 1) % 8));

    cur_tag = "R4";
    if (idx[0]) pulse(3, 3);
    mode = 3'b001;
    for (int i = 0; i < 6; i++) begin
      pulse(3, 3);
      chk("R4", 8'(idx[0]), 8'd1);
    end
    dir = 1'b0;
    repeat (3) pulse(3, 3);
    dir = 1'b1;

    cur_tag = "R5";
    mode = 3'b010;
    for (int i = 0; i < 6; i++) begin
      pulse(3, 3);
      chk("R5", 8'(idx[0]), 8'd0);
    end

    cur_tag = "R11";
    p0 = int'(idx);
    mode = 3'b001; dir = 1'b0;
    repeat (10) @(negedge clk);
    mode = 3'b000;
    repeat (5) @(negedge clk);
    chk("R11", 8'(idx), 8'(p0));
    dir = 1'b1;

    cur_tag = "R8";
    sleep1 = 1'b1;
    p0 = int'(idx);
    repeat (3) pulse(3, 3);
    chk("R8", {5'd0, oen, a_en, b_en}, 8'd0);
    chk("R8", 8'(idx), 8'((p0 + 3) % 8));
    sleep1 = 1'b0;
    @(negedge clk);

    cur_tag = "R9";
    mode = 3'b111;
    repeat (3) pulse(3, 3);
    chk("R9", 8'(idx), 8'd1);
    chk("R9", {5'd0, oen, a_en, b_en}, 8'd0);
    mode = 3'b000;

    cur_tag = "R2";
    repeat (2) pulse(3, 3);
    @(negedge clk) seq_rst = 1'b1;
    step = 1'b1;
    @(negedge clk) seq_rst = 1'b0;
    chk("R2", 8'(idx), 8'd1);
    step = 1'b0;
    repeat (4) @(negedge clk);

    cur_tag = "R10";
    sync_req = 1'b1;
    repeat (5) pulse(3, 3);
    chk("R10", 8'(sen), 8'd0);
    repeat (HOLD + 2) @(negedge clk);
    chk("R10", 8'(sen), 8'd1);
    mode = 3'b001;
    repeat (3) pulse(3, 3);
    chk("R10", 8'(sen), 8'd1);
    sleep1 = 1'b1;
    @(negedge clk);
    chk("R10", 8'(sen), 8'd0);
    sleep1 = 1'b0; sync_req = 1'b0; mode = 3'b000;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      vecs++; miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule